// File: doc/BRIEF.md
# Sleep-Clamped General-Purpose I/O Port

This block is a parameterised general-purpose I/O port, eight pins wide by default. For each pin it holds an output bit and a direction bit. From these it produces three pad controls: an output enable, an output level and a pull-up enable. An external pad model turns those controls into the level seen on each pin. That level returns to the block, passes a two-stage synchronizer and becomes the readable input value.

The chip's power manager reports a sleep-mode code. When the code names one of the deep modes, the block forces each pin's digital input to 0 so that a floating pin cannot toggle the logic. A pin whose external interrupt is enabled bypasses this clamp.

Each pin also has an edge detector. It watches the synchronized, clamped input and sets a sticky flag on a rising edge, a falling edge or any change. The flag is set whether or not the pin's interrupt is enabled. This means that leaving deep sleep with a pin held high can set a flag even though that pin's interrupt is off.

Top module: `gpio_sleep_port`

## Requirements
- R1: After reset the output register, direction register, input readout and all flags are 0.
- R2: A write strobe on the output or direction port loads that register from its write data at the next clock edge. Both registers may be written in the same cycle.
- R3: A pin whose direction bit is 1 has its pad output enable set and its pad output equal to its output bit, and its pull-up is off.
- R4: A pin whose direction bit is 0 has its output enable off. Its pull-up enable equals its output bit.
- R5: The input readout shows a pin level two clock edges after it is captured. A read in the cycle right after an output or direction write still shows the old level.
- R6: Sleep-mode codes 1, 2 and 3 (the deep modes) force the digital input of every pin whose interrupt enable is 0 to 0. Codes 0 and 4 to 7 pass all pins unchanged.
- R7: During a deep mode, a pin whose interrupt enable is 1 passes its real level.
- R8: Each pin has a two-bit sense field at bits [2i+1:2i]. Bit 2i selects rising edges and bit 2i+1 selects falling edges, so 01 means rising, 10 falling, 11 any change and 00 none. A selected transition of the synchronized input sets the pin's flag, whatever the interrupt enable.
- R9: When a deep mode ends with a pin held high, the resulting 0-to-1 transition sets the flag of a pin set to rising or any change.
- R10: Writing a 1 to a flag-clear bit clears that flag. A set event in the same cycle wins over the clear.
- R11: The interrupt output is 1 exactly when some pin has both its flag and its interrupt enable set.
- R12: No flag is set during the first three clock edges after reset, even if an input is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_we | input | 1 | Output register write strobe |
| out_wdata | input | W | Output register write data |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | W | Direction register write data |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_data | input | W | Flags to clear (1 clears) |
| int_en | input | W | Per-pin external interrupt enable |
| sense | input | 2*W | Per-pin edge select, 2 bits per pin |
| sleep_mode | input | 3 | Sleep-mode code from the power manager |
| pad_in | input | W | Pin levels from the pad |
| out_reg | output | W | Output register |
| dir_reg | output | W | Direction register |
| pin_rd | output | W | Synchronized input readout |
| pad_oe | output | W | Pad output enable |
| pad_out | output | W | Pad output level |
| pad_pu | output | W | Pad pull-up enable |
| flag | output | W | Sticky edge flags |
| irq | output | 1 | Enabled-flag interrupt request |

## Verification
The bench builds the block with the default width of 8. This puts clamped pins, exempt pins and pins in all four sense settings in one port, so a single input pattern exercises several cases at once. A table sweeps all the sleep-mode code groups against mixed interrupt-enable masks. Directed tests then cover the write-to-read latency, the wake-up flag, and a clear that lands on the same edge as a set.

// File: rtl/gpio_sleep_port.sv
module gpio_sleep_port #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           out_we,
  input  logic [W-1:0]   out_wdata,
  input  logic           dir_we,
  input  logic [W-1:0]   dir_wdata,
  input  logic           flag_clr_we,
  input  logic [W-1:0]   flag_clr_data,
  input  logic [W-1:0]   int_en,
  input  logic [2*W-1:0] sense,
  input  logic [2:0]     sleep_mode,
  input  logic [W-1:0]   pad_in,
  output logic [W-1:0]   out_reg,
  output logic [W-1:0]   dir_reg,
  output logic [W-1:0]   pin_rd,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_out,
  output logic [W-1:0]   pad_pu,
  output logic [W-1:0]   flag,
  output logic           irq
);
  localparam logic [2:0] MODE_PDOWN = 3'd1;
  localparam logic [2:0] MODE_PSAVE = 3'd2;
  localparam logic [2:0] MODE_STBY  = 3'd3;

  logic           clamp;
  logic [W-1:0]   gated, sync1, sync2, prev, set_evt, clr_mask;
  logic [2:0]     warm;

  assign pad_oe  = dir_reg;
  assign pad_out = out_reg & dir_reg;
  assign pad_pu  = out_reg & ~dir_reg;

  assign clamp = (sleep_mode == MODE_PDOWN) || (sleep_mode == MODE_PSAVE) ||
                 (sleep_mode == MODE_STBY);
  assign gated = pad_in & (clamp ? int_en : {W{1'b1}});
  assign pin_rd = sync2;

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign set_evt[i] = warm[2] &
      ((sense[2*i]   &  sync2[i] & ~prev[i]) |
       (sense[2*i+1] & ~sync2[i] &  prev[i]));
  end

  assign clr_mask = flag_clr_we ? flag_clr_data : '0;
  assign irq = |(flag & int_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_reg <= '0;
      dir_reg <= '0;
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      warm    <= '0;
      flag    <= '0;
    end else begin
      if (out_we) out_reg <= out_wdata;
      if (dir_we) dir_reg <= dir_wdata;
      sync1 <= gated;
      sync2 <= sync1;
      prev  <= sync2;
      warm  <= {warm[1:0], 1'b1};
      flag  <= (flag & ~clr_mask) | set_evt;
    end
  end

  // R6
  clamp_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |=> ((sync1 & ~$past(int_en)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flag & $past(set_evt)) == $past(set_evt)));

  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_we |=> ((flag & $past(flag_clr_data & ~set_evt)) == '0));

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (dir_reg == $past(dir_wdata)));

  // R12
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm[2] |-> (set_evt == '0));
endmodule

// File: tb/gpio_sleep_port_tb.sv
module gpio_sleep_port_tb;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic out_we = 0, dir_we = 0, flag_clr_we = 0;
  logic [W-1:0] out_wdata = '0, dir_wdata = '0, flag_clr_data = '0, int_en = '0;
  logic [2*W-1:0] sense = '0;
  logic [2:0] sleep_mode = '0;
  logic [W-1:0] ext_en = '1, ext_val = '0;
  logic [W-1:0] pad_in, out_reg, dir_reg, pin_rd, pad_oe, pad_out, pad_pu, flag;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) |
                  (~pad_oe & ((ext_en & ext_val) | (~ext_en & pad_pu)));

  gpio_sleep_port #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .out_we(out_we), .out_wdata(out_wdata),
    .dir_we(dir_we), .dir_wdata(dir_wdata), .flag_clr_we(flag_clr_we),
    .flag_clr_data(flag_clr_data), .int_en(int_en), .sense(sense),
    .sleep_mode(sleep_mode), .pad_in(pad_in), .out_reg(out_reg),
    .dir_reg(dir_reg), .pin_rd(pin_rd), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .flag(flag), .irq(irq));

  // {sleep_mode, int_en, ext_val, expected pin_rd}
  localparam logic [26:0] VEC [0:7] = '{
    {3'd0, 8'h00, 8'hA5, 8'hA5},
    {3'd1, 8'h00, 8'hFF, 8'h00},
    {3'd2, 8'h0F, 8'hFF, 8'h0F},
    {3'd3, 8'hF0, 8'h3C, 8'h30},
    {3'd4, 8'h00, 8'h5A, 8'h5A},
    {3'd7, 8'h00, 8'hC3, 8'hC3},
    {3'd1, 8'h81, 8'h81, 8'h81},
    {3'd0, 8'hFF, 8'h00, 8'h00}
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr_we = 1; flag_clr_data = '1;
    cyc(1);
    flag_clr_we = 0; flag_clr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    check("R1 out", out_reg, 8'h00);
    check("R1 dir", dir_reg, 8'h00);
    check("R1 pin", pin_rd, 8'h00);
    check("R1 flag", flag, 8'h00);
    rst_n = 1;
    cyc(4);

    // R6 R7 table
    for (int k = 0; k < 8; k++) begin
      sleep_mode = VEC[k][26:24];
      int_en     = VEC[k][23:16];
      ext_val    = VEC[k][15:8];
      cyc(3);
      check($sformatf("R6/R7 vec%0d", k), pin_rd, VEC[k][7:0]);
    end
    sleep_mode = 0; int_en = 0;

    // R2 R3
    ext_en = '0;
    out_we = 1; out_wdata = 8'h0F; dir_we = 1; dir_wdata = 8'hFF;
    cyc(1);
    out_we = 0; dir_we = 0;
    check("R2 out", out_reg, 8'h0F);
    check("R2 dir", dir_reg, 8'hFF);
    check("R3 oe", pad_oe, 8'hFF);
    check("R3 out", pad_out, 8'h0F);
    check("R3 pu", pad_pu, 8'h00);
    cyc(3);
    check("R5 settled", pin_rd, 8'h0F);

    // R5 latency
    out_we = 1; out_wdata = 8'hF0;
    cyc(1);
    out_we = 0;
    check("R5 read after write", pin_rd, 8'h0F);
    cyc(1);
    check("R5 extra cycle", pin_rd, 8'h0F);
    cyc(1);
    check("R5 new", pin_rd, 8'hF0);

    // R4
    dir_we = 1; dir_wdata = 8'h00; out_we = 1; out_wdata = 8'h55;
    cyc(1);
    dir_we = 0; out_we = 0;
    check("R4 pu", pad_pu, 8'h55);
    check("R4 oe", pad_oe, 8'h00);
    cyc(3);
    check("R4 pin", pin_rd, 8'h55);

    // R8
    out_we = 1; out_wdata = 8'h00;
    ext_en = '1; ext_val = '0;
    sense = 16'b00_00_00_00_00_11_10_01;
    cyc(1);
    out_we = 0;
    cyc(4);
    clear_all();
    ext_val = 8'h0F;
    cyc(4);
    check("R8 rise", flag, 8'h05);
    clear_all();
    ext_val = 8'h09;
    cyc(4);
    check("R8 fall", flag, 8'h06);

    // R11
    int_en = 8'h04; #1;
    check("R11 on", {7'd0, irq}, 8'h01);
    int_en = 8'h01; #1;
    check("R11 off", {7'd0, irq}, 8'h00);
    int_en = 8'h00;

    // R10 clear
    flag_clr_we = 1; flag_clr_data = 8'h02;
    cyc(1);
    flag_clr_we = 0;
    check("R10 clear", flag, 8'h04);
    // R10 set wins: pin0 falls then rises, set lands on the clear cycle
    ext_val = 8'h08;
    cyc(4);
    ext_val = 8'h09;
    cyc(2);
    flag_clr_we = 1; flag_clr_data = 8'h05;
    cyc(1);
    flag_clr_we = 0;
    check("R10 set wins", flag, 8'h01);

    // R9 wake
    ext_val = 8'h05;
    cyc(4);
    sleep_mode = 3'd2;
    cyc(4);
    check("R6 asleep", pin_rd, 8'h00);
    clear_all();
    cyc(1);
    check("R9 cleared", flag, 8'h00);
    sleep_mode = 3'd0;
    cyc(4);
    check("R9 wake", flag, 8'h05);

    // R12
    rst_n = 0; ext_val = '1;
    cyc(1);
    rst_n = 1;
    cyc(6);
    check("R12 no flag", flag, 8'h00);
    check("R12 pin", pin_rd, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule